// File: doc/BRIEF.md
# Chained Seven-Segment Digit Decoder with Zero Suppression and Dimming

This block turns a row of 4-bit decimal digit codes into active-high drive patterns for seven-segment displays. Each digit has its own cell. All cells share an active-low lamp-test control and an active-low blanking control. A cell lights the glyph for its code, lights every segment during lamp test, or stays dark when it is blanked.

The cells form a chain from the most significant digit to the least significant one, and this chain suppresses leading zeros. A cell whose incoming suppress flag is low and whose code is zero stays dark and pulls its outgoing flag low. That outgoing flag is also the cell's own blanking node, modelled as a wired-AND. The most significant digit always starts with the flag low. The least significant digit always has its flag forced high, so a value of zero still shows one "0".

An internal pulse-width dimmer also drives the shared blanking node. It compares a free-running counter against a duty input to set display brightness. Segment patterns and per-digit suppress flags are registered, so they appear one clock after the inputs.

Top module: `seg_display_chain`

## Requirements
- R1: With segment bit order {g,f,e,d,c,b,a} (a in bit 0) and digit i in `bcd_in[4i+3:4i]` / `seg_out[7i+6:7i]`, codes 0..9 show 3F, 06, 5B, 4F, 66, 6D, 7C, 07, 7F, 67 (hex) when nothing blanks or overrides them.
- R2: Codes 10..15 show 58, 4C, 62, 69, 78 and 00 (hex). A code of 15 is still a nonzero code for suppression.
- R3: While `blank_n` is low, every segment of every digit is off and every `ripple_out_n` bit is low, whatever the other inputs are. This condition outranks all others.
- R4: While the effective blanking (external AND dimmer) is inactive and `lamp_test_n` is low, all seven segments of every digit are on, whatever the codes are, and no digit is suppressed.
- R5: A digit whose incoming suppress flag is low, whose code is 0 and with `lamp_test_n` high has all segments off and drives its `ripple_out_n` bit low. That bit is the incoming flag of the next less significant digit.
- R6: The incoming suppress flag has no effect on a nonzero code. A nonzero digit drives its `ripple_out_n` high, so the zeros after it are shown as "0".
- R7: The most significant digit's incoming flag is tied low. The least significant digit's flag is forced high, so an all-zero value shows only "0" in digit 0.
- R8: An internal counter of `PWM_W` bits runs freely from 0 after reset. The display is blanked in every cycle in which the counter is greater than or equal to `duty`. A duty of 0 keeps it dark, and a duty of D gives D lit cycles out of every 2^PWM_W.
- R9: Outputs are registered on the rising edge, so an input change appears one clock later. A synchronous active-high `rst` turns all segments off, sets `ripple_out_n` all high and restarts the counter at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bcd_in | input | 4*NUM_DIGITS | Digit codes, digit 0 least significant |
| lamp_test_n | input | 1 | Active-low light-all control |
| blank_n | input | 1 | Active-low external blanking |
| duty | input | PWM_W | Dimmer duty value |
| seg_out | output | 7*NUM_DIGITS | Registered segment drives, active high |
| ripple_out_n | output | NUM_DIGITS | Registered per-digit blanking node (suppress flag) |

## Verification
Some rules are checked on every cycle: forced blanking darkens all digits and all flags, lamp test lights every segment while the display is not blanked, an all-zero most significant digit goes dark and passes its flag low, a zero in digit 0 always shows "0", and the dimmer counter steps by one and blanks at its top value. Other behaviour is shown only by the bench's scenarios. These cover the glyph of each of the 16 codes, how a nonzero digit in the middle stops suppression, the interaction of every code with each control combination, the one-cycle latency and reset values, and the count of lit cycles for a given duty value.

// File: rtl/seg_pkg.sv
package seg_pkg;

    localparam int SEG_W  = 7;
    localparam int CODE_W = 4;

    typedef logic [SEG_W-1:0]  seg_t;
    typedef logic [CODE_W-1:0] code_t;

    localparam seg_t SEG_OFF = 7'h00;
    localparam seg_t SEG_ALL = 7'h7F;

endpackage

// File: rtl/seg_glyph_decode.sv
module seg_glyph_decode
    import seg_pkg::*;
(
    input  logic [3:0] code,
    output logic [6:0] glyph
);

    // Bit order {g,f,e,d,c,b,a}
    always_comb begin
        unique case (code)
            4'd0:  glyph = 7'h3F;
            4'd1:  glyph = 7'h06;
            4'd2:  glyph = 7'h5B;
            4'd3:  glyph = 7'h4F;
            4'd4:  glyph = 7'h66;
            4'd5:  glyph = 7'h6D;
            4'd6:  glyph = 7'h7C;
            4'd7:  glyph = 7'h07;
            4'd8:  glyph = 7'h7F;
            4'd9:  glyph = 7'h67;
            4'd10: glyph = 7'h58;
            4'd11: glyph = 7'h4C;
            4'd12: glyph = 7'h62;
            4'd13: glyph = 7'h69;
            4'd14: glyph = 7'h78;
            default: glyph = SEG_OFF;
        endcase
    end

endmodule

// File: rtl/seg_digit_cell.sv
module seg_digit_cell
    import seg_pkg::*;
(
    input  logic [3:0] code,
    input  logic       lamp_n,
    input  logic       rbi_n,
    input  logic       bi_n,
    output logic [6:0] seg,
    output logic       node_n
);

    logic [6:0] glyph;
    logic       zero_pull;

    seg_glyph_decode u_dec (
        .code  (code),
        .glyph (glyph)
    );

    // Cell pulls its own blanking node low for a suppressed zero
    assign zero_pull = !rbi_n && (code == 4'd0) && lamp_n;
    // Wired-AND of the shared blanking line and the cell's own pull
    assign node_n    = bi_n && !zero_pull;

    always_comb begin
        if (!node_n) begin
            seg = SEG_OFF;
        end else if (!lamp_n) begin
            seg = SEG_ALL;
        end else begin
            seg = glyph;
        end
    end

endmodule

// File: rtl/seg_pwm_dimmer.sv
module seg_pwm_dimmer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] duty,
    output logic             lit
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (rst) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    assign lit = (cnt_q < duty);

    // R8
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

    // R8
    top_blank_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == {CNT_W{1'b1}}) |-> !lit);

endmodule

// File: rtl/seg_display_chain.sv
module seg_display_chain
    import seg_pkg::*;
#(
    parameter int NUM_DIGITS = 4,
    parameter int PWM_W      = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [CODE_W*NUM_DIGITS-1:0] bcd_in,
    input  logic                         lamp_test_n,
    input  logic                         blank_n,
    input  logic [PWM_W-1:0]             duty,
    output logic [SEG_W*NUM_DIGITS-1:0]  seg_out,
    output logic [NUM_DIGITS-1:0]        ripple_out_n
);

    localparam int SEG_BITS = SEG_W * NUM_DIGITS;
    localparam int MSD      = NUM_DIGITS - 1;

    logic                  pwm_lit;
    logic                  eff_bi_n;
    logic [NUM_DIGITS-1:0] rbi_n;
    logic [NUM_DIGITS-1:0] node_n;
    logic [SEG_BITS-1:0]   cell_seg;

    seg_pwm_dimmer #(
        .CNT_W (PWM_W)
    ) u_pwm (
        .clk  (clk),
        .rst  (rst),
        .duty (duty),
        .lit  (pwm_lit)
    );

    assign eff_bi_n = blank_n & pwm_lit;

    for (genvar gi = 0; gi < NUM_DIGITS; gi++) begin : g_digit
        if (gi == 0) begin : g_lsd
            assign rbi_n[gi] = 1'b1;
        end else if (gi == MSD) begin : g_msd
            assign rbi_n[gi] = 1'b0;
        end else begin : g_mid
            assign rbi_n[gi] = node_n[gi+1];
        end

        seg_digit_cell u_cell (
            .code   (bcd_in[CODE_W*gi +: CODE_W]),
            .lamp_n (lamp_test_n),
            .rbi_n  (rbi_n[gi]),
            .bi_n   (eff_bi_n),
            .seg    (cell_seg[SEG_W*gi +: SEG_W]),
            .node_n (node_n[gi])
        );
    end

    typedef struct packed {
        logic [SEG_BITS-1:0]   seg;
        logic [NUM_DIGITS-1:0] rbo_n;
    } disp_t;

    disp_t disp_d, disp_q;

    always_comb begin
        if (rst) begin
            disp_d.seg   = '0;
            disp_d.rbo_n = '1;
        end else begin
            disp_d.seg   = cell_seg;
            disp_d.rbo_n = node_n;
        end
    end

    always_ff @(posedge clk) begin
        disp_q <= disp_d;
    end

    assign seg_out      = disp_q.seg;
    assign ripple_out_n = disp_q.rbo_n;

    // R3
    blank_dark_chk: assert property (@(posedge clk) disable iff (rst)
        !blank_n |=> (seg_out == '0) && (ripple_out_n == '0));

    // R4
    lamp_all_chk: assert property (@(posedge clk) disable iff (rst)
        (blank_n && pwm_lit && !lamp_test_n) |=> (seg_out == '1) && (ripple_out_n == '1));

    // R7
    lsd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (blank_n && pwm_lit && lamp_test_n && bcd_in[CODE_W-1:0] == '0)
            |=> seg_out[SEG_W-1:0] == 7'h3F);

    if (NUM_DIGITS > 1) begin : g_msd_chk
        // R5
        msd_suppress_chk: assert property (@(posedge clk) disable iff (rst)
            (lamp_test_n && bcd_in[CODE_W*MSD +: CODE_W] == '0)
                |=> (seg_out[SEG_W*MSD +: SEG_W] == '0) && !ripple_out_n[MSD]);
    end

endmodule

// File: tb/tb_seg_display_chain.sv
module tb_seg_display_chain;

    localparam int N  = 4;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [4*N-1:0] bcd = '0;
    logic          lamp_n = 1'b1;
    logic          blank_n = 1'b1;
    logic [PW-1:0] duty = '1;
    logic [7*N-1:0] seg;
    logic [N-1:0]  rbo;

    always #5 clk = ~clk;

    seg_display_chain #(
        .NUM_DIGITS (N),
        .PWM_W      (PW)
    ) dut (
        .clk          (clk),
        .rst          (rst),
        .bcd_in       (bcd),
        .lamp_test_n  (lamp_n),
        .blank_n      (blank_n),
        .duty         (duty),
        .seg_out      (seg),
        .ripple_out_n (rbo)
    );

    int checks = 0;
    int errors = 0;

    localparam logic [6:0] GLYPH [16] = '{
        7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7C, 7'h07,
        7'h7F, 7'h67, 7'h58, 7'h4C, 7'h62, 7'h69, 7'h78, 7'h00
    };

    // {bcd, lamp_n, blank_n, expected seg {d3,d2,d1,d0}, expected flags}
    localparam logic [49:0] VEC [10] = '{
        {16'h0000, 1'b1, 1'b1, {7'h00, 7'h00, 7'h00, 7'h3F}, 4'b0001}, // R7
        {16'h0102, 1'b1, 1'b1, {7'h00, 7'h06, 7'h3F, 7'h5B}, 4'b0111}, // R6
        {16'h0030, 1'b1, 1'b1, {7'h00, 7'h00, 7'h4F, 7'h3F}, 4'b0011}, // R5
        {16'hF000, 1'b1, 1'b1, {7'h00, 7'h3F, 7'h3F, 7'h3F}, 4'b1111}, // R2
        {16'h9876, 1'b1, 1'b1, {7'h67, 7'h7F, 7'h07, 7'h7C}, 4'b1111}, // R1
        {16'h5432, 1'b1, 1'b1, {7'h6D, 7'h66, 7'h4F, 7'h5B}, 4'b1111}, // R1
        {16'hBCDE, 1'b1, 1'b1, {7'h4C, 7'h62, 7'h69, 7'h78}, 4'b1111}, // R2
        {16'h00A1, 1'b1, 1'b1, {7'h00, 7'h00, 7'h58, 7'h06}, 4'b0011}, // R2
        {16'h0000, 1'b0, 1'b1, {7'h7F, 7'h7F, 7'h7F, 7'h7F}, 4'b1111}, // R4
        {16'h1234, 1'b1, 1'b0, {7'h00, 7'h00, 7'h00, 7'h00}, 4'b0000}  // R3
    };

    function automatic string vec_tag(input int v);
        case (v)
            0:       return "R7";
            1:       return "R6";
            2:       return "R5";
            3, 6, 7: return "R2";
            4, 5:    return "R1";
            8:       return "R4";
            default: return "R3";
        endcase
    endfunction

    function automatic string sweep_tag(input int code, input int lt, input int bi, input int p);
        if (bi == 0)      return "R3";
        else if (lt == 0) return "R4";
        else if (p == 1)  return "R5";
        else if (p == 2)  return "R6";
        else if (code == 0) return "R7";
        else if (code < 10) return "R1";
        else              return "R2";
    endfunction

    // Reference from the requirements: returns {flags, segments}
    function automatic logic [7*N+N-1:0] model(input logic [4*N-1:0] w,
                                               input logic lt, input logic bi);
        logic [7*N-1:0] s;
        logic [N-1:0]   r;
        logic           prev;
        s = '0;
        r = '0;
        prev = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            logic       rin;
            logic [3:0] c;
            logic       node;
            rin  = (i == 0) ? 1'b1 : ((i == N - 1) ? 1'b0 : prev);
            c    = w[4*i +: 4];
            node = bi && !(!rin && c == 4'd0 && lt);
            s[7*i +: 7] = !node ? 7'h00 : (!lt ? 7'h7F : GLYPH[c]);
            r[i] = node;
            prev = node;
        end
        return {r, s};
    endfunction

    logic [PW-1:0]  bcnt;
    logic [7*N-1:0] exp_seg;
    logic [N-1:0]   exp_rbo;

    always @(posedge clk) begin
        if (rst) begin
            exp_seg <= '0;
            exp_rbo <= '1;
            bcnt    <= '0;
        end else begin
            {exp_rbo, exp_seg} <= model(bcd, lamp_n, blank_n && (bcnt < duty));
            bcnt <= bcnt + 1'b1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL R9 watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0]    vb;
        logic           vl, vk;
        logic [27:0]    vs;
        logic [3:0]     vr;
        int             lit_cnt;

        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9", 32'(seg), 32'h0);
        check("R9", 32'(rbo), 32'hF);
        rst = 1'b0;

        // Table walk with explicit expected patterns
        for (int v = 0; v < 10; v++) begin
            {vb, vl, vk, vs, vr} = VEC[v];
            bcd = vb;
            lamp_n = vl;
            blank_n = vk;
            @(negedge clk);
            check(vec_tag(v), 32'(seg), 32'(vs));
            check(vec_tag(v), 32'(rbo), 32'(vr));
        end

        // R9 one-cycle latency: old value holds until the next edge
        bcd = 16'h0008;
        lamp_n = 1'b1;
        blank_n = 1'b1;
        #1;
        check("R9", 32'(seg), 32'h0);
        @(negedge clk);
        check("R9", 32'(seg), 32'(28'h000007F));

        // Every code against every control combination
        for (int code = 0; code < 16; code++) begin
            for (int lt = 0; lt < 2; lt++) begin
                for (int bi = 0; bi < 2; bi++) begin
                    for (int p = 0; p < 3; p++) begin
                        logic [3:0] c;
                        c = 4'(code);
                        case (p)
                            0:       bcd = {c, c, c, c};
                            1:       bcd = {4'h0, 4'h0, c, 4'h0};
                            default: bcd = {4'h0, c, 4'h0, 4'h5};
                        endcase
                        lamp_n = lt[0];
                        blank_n = bi[0];
                        @(negedge clk);
                        check(sweep_tag(code, lt, bi, p), 32'(seg), 32'(exp_seg));
                        check(sweep_tag(code, lt, bi, p), 32'(rbo), 32'(exp_rbo));
                    end
                end
            end
        end

        // R8 dimmer: zero duty stays dark
        bcd = 16'h8888;
        lamp_n = 1'b1;
        blank_n = 1'b1;
        duty = 8'd0;
        @(negedge clk);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            check("R8", 32'(seg), 32'h0);
        end

        // R8 lit cycles per full counter period
        duty = 8'd128;
        @(negedge clk);
        lit_cnt = 0;
        for (int k = 0; k < 256; k++) begin
            @(negedge clk);
            if (seg != '0) lit_cnt++;
        end
        check("R8", 32'(lit_cnt), 32'd128);

        duty = 8'd255;
        @(negedge clk);
        lit_cnt = 0;
        for (int k = 0; k < 256; k++) begin
            @(negedge clk);
            if (seg != '0) lit_cnt++;
        end
        check("R8", 32'(lit_cnt), 32'd255);

        duty = 8'd1;
        @(negedge clk);
        lit_cnt = 0;
        for (int k = 0; k < 256; k++) begin
            @(negedge clk);
            if (seg != '0) lit_cnt++;
        end
        check("R8", 32'(lit_cnt), 32'd1);

        // R9 reset mid-run clears outputs
        duty = 8'd255;
        rst = 1'b1;
        @(negedge clk);
        check("R9", 32'(seg), 32'h0);
        check("R9", 32'(rbo), 32'hF);
        rst = 1'b0;

        finish_run();
    end

endmodule